// File: doc/BRIEF.md
# Indexed CMOS Register File

This block is a 256-byte configuration and timekeeping store. A host bus reaches it through two byte-wide ports. Address bit 0 low selects the index port, which is the even port of the pair (0x70). Address bit 0 high selects the data port, which is the odd port (0x71). A write to the index port records which location the next data-port accesses use. A read or write of the data port then reaches that location. Each location has a written flag, and the flags are kept as 32 groups of 8. A data-port read of a location that has never been written reports an error instead of data.

Location 0x0A is the status-A byte. Every data-port read of it returns its current value and then inverts bit 7, the update-in-progress bit. Software that polls this bit therefore sees it change.

A second, unregistered side port serves the timekeeping logic, which reads and writes time and status bytes through it. Reset loads default status bytes and a default date and time, and marks those locations as written.

Top module: `cmos_regfile`

## Requirements
- R1: An index-port write (`bus_a0`=0) latches all 8 bits of `bus_wdata` and changes no stored byte. An index-port read returns the latched index with `bus_rerr`=0. The index is 0x00 after reset.
- R2: From reset until the first index-port write, the block is in its ready state. In that state a data-port read returns 0x00 with `bus_rerr`=1, and a data-port write changes nothing.
- R3: After any index-port write, a data-port write stores `bus_wdata` at the indexed location and marks the location written. A later data-port read returns that byte with `bus_rerr`=0.
- R4: A data-port read of a location never written returns 0x00 with `bus_rerr`=1.
- R5: A data-port read of location 0x0A returns its value as it was before the read and then inverts bit 7 of that location. Reads of other locations and index-port reads leave storage unchanged.
- R6: Reset loads the following bytes, all marked written: 0x00..0x05 = 0x00, 0x06 = 0x01, 0x07 = 0x01, 0x08 = 0x01, 0x09 = 0x08, 0x0A = 0x26, 0x0B = 0x06, 0x0C = 0x00, 0x0D = 0x80. Every location from 0x0E up is marked unwritten.
- R7: `bus_rdata` and `bus_rerr` change only on the clock edge that samples `bus_rd`, and they hold their values until the next read.
- R8: `tk_rdata` shows the current byte at `tk_addr` in the same cycle. A side write (`tk_wr`) stores `tk_wdata` at `tk_addr` and marks the location written.
- R9: If a bus data write or a status-A read inversion hits the same location as a side write in the same cycle, the bus result wins. Writes to different locations in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_a0 | input | 1 | Port select: 0 index port, 1 data port |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rerr | output | 1 | Registered read error flag |
| tk_addr | input | 8 | Side-port location |
| tk_wr | input | 1 | Side-port write enable |
| tk_wdata | input | 8 | Side-port write data |
| tk_rdata | output | 8 | Side-port read data, combinational |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `tk_addr` does not move in the cycle in which a side write lands. The bench performs exactly one operation per call, drives each strobe for a single cycle, and deasserts it before the next operation starts. Same-cycle bus and side collisions appear only in directed cases, so the random stream can be predicted with a simple one-operation-at-a-time model.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

  localparam int unsigned STAT_A_LOC = 10;
  localparam int unsigned UIP_BIT    = 7;
  localparam int unsigned N_DEFAULT  = 14;

  typedef enum logic {
    ST_READY  = 1'b0,
    ST_POSTED = 1'b1
  } idx_state_e;

  // Power-on contents of the time and status locations.
  function automatic logic [7:0] dflt_byte(input int unsigned loc);
    case (loc)
      6, 7, 8: dflt_byte = 8'h01;
      9:       dflt_byte = 8'h08;
      10:      dflt_byte = 8'h26;
      11:      dflt_byte = 8'h06;
      13:      dflt_byte = 8'h80;
      default: dflt_byte = 8'h00;
    endcase
  endfunction

  function automatic logic dflt_vld(input int unsigned loc);
    dflt_vld = (loc < N_DEFAULT);
  endfunction

endpackage

// File: rtl/cmos_index_ctl.sv
module cmos_index_ctl
  import cmos_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [ADDR_W-1:0] idx_wdata,
  output logic [ADDR_W-1:0] idx_q,
  output idx_state_e        state_q
);

  logic [ADDR_W-1:0] idx_d;
  idx_state_e        state_d;
  logic              idx_en;

  always_comb begin
    idx_en  = idx_wr;
    idx_d   = idx_wdata;
    state_d = state_q;
    if (idx_wr) begin
      state_d = ST_POSTED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      state_q <= ST_READY;
    end else begin
      state_q <= state_d;
      if (idx_en) begin
        idx_q <= idx_d;
      end
    end
  end

endmodule

// File: rtl/cmos_store.sv
module cmos_store
  import cmos_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STAT_LOC = STAT_A_LOC,
  parameter int unsigned TOG_BIT  = UIP_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              tog_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_byte,
  output logic              bus_vld,
  input  logic              tk_we,
  input  logic [ADDR_W-1:0] tk_addr,
  input  logic [DATA_W-1:0] tk_wdata,
  output logic [DATA_W-1:0] tk_byte,
  output logic [DATA_W-1:0] stat_byte
);

  localparam int unsigned NUM_LOC = 1 << ADDR_W;
  localparam int unsigned GRP_W   = 8;
  localparam int unsigned NUM_GRP = NUM_LOC / GRP_W;
  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOG_BIT;

  logic [DATA_W-1:0] mem  [NUM_LOC];
  logic [GRP_W-1:0]  vmap [NUM_GRP];

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    localparam logic [DATA_W-1:0] RST_BYTE = DATA_W'(dflt_byte(i));
    localparam logic              RST_VLD  = dflt_vld(i);
    localparam logic [ADDR_W-1:0] MY_ADDR  = ADDR_W'(i);

    logic [DATA_W-1:0] byte_q, byte_d;
    logic              vld_q, vld_d;
    logic              byte_en;
    logic              hit_bus, hit_tog, hit_tk;

    always_comb begin
      hit_bus = bus_we && (bus_addr == MY_ADDR);
      hit_tog = tog_en && (i == STAT_LOC);
      hit_tk  = tk_we && (tk_addr == MY_ADDR);
      byte_en = hit_bus || hit_tog || hit_tk;
      vld_d   = vld_q || hit_bus || hit_tk;
      if (hit_bus) begin
        byte_d = bus_wdata;
      end else if (hit_tog) begin
        byte_d = byte_q ^ TOG_MASK;
      end else begin
        byte_d = tk_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= RST_BYTE;
        vld_q  <= RST_VLD;
      end else begin
        vld_q <= vld_d;
        if (byte_en) begin
          byte_q <= byte_d;
        end
      end
    end

    assign mem[i] = byte_q;
    assign vmap[i / GRP_W][i % GRP_W] = vld_q;
  end

  always_comb begin
    bus_byte  = mem[bus_addr];
    bus_vld   = vmap[bus_addr / GRP_W][bus_addr % GRP_W];
    tk_byte   = mem[tk_addr];
    stat_byte = mem[STAT_LOC];
  end

endmodule

// File: rtl/cmos_read_path.sv
module cmos_read_path
  import cmos_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STAT_LOC = STAT_A_LOC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              port_data,
  input  idx_state_e        state,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] sel_byte,
  input  logic              sel_vld,
  output logic              tog_en,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rerr_q
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_LOC);

  logic [DATA_W-1:0] rdata_d;
  logic              rerr_d;
  logic              data_ok;

  always_comb begin
    data_ok = (state == ST_POSTED) && sel_vld;
    tog_en  = rd_en && port_data && data_ok && (idx == STAT_ADDR);
    if (!port_data) begin
      rdata_d = DATA_W'(idx);
      rerr_d  = 1'b0;
    end else if (data_ok) begin
      rdata_d = sel_byte;
      rerr_d  = 1'b0;
    end else begin
      rdata_d = '0;
      rerr_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rerr_q  <= 1'b0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
      rerr_q  <= rerr_d;
    end
  end

endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_a0,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rerr,
  input  logic [ADDR_W-1:0] tk_addr,
  input  logic              tk_wr,
  input  logic [DATA_W-1:0] tk_wdata,
  output logic [DATA_W-1:0] tk_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [ADDR_W-1:0] idx_q;
  idx_state_e        state_q;
  logic              idx_wr, data_we, tog_en;
  logic [DATA_W-1:0] sel_byte, stat_byte;
  logic              sel_vld;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    idx_wr  = bus_wr && !bus_a0;
    data_we = bus_wr && bus_a0 && (state_q == ST_POSTED);
  end

  cmos_index_ctl #(.ADDR_W(ADDR_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .idx_wr    (idx_wr),
    .idx_wdata (ADDR_W'(bus_wdata)),
    .idx_q     (idx_q),
    .state_q   (state_q)
  );

  cmos_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_we    (data_we),
    .tog_en    (tog_en),
    .bus_addr  (idx_q),
    .bus_wdata (bus_wdata),
    .bus_byte  (sel_byte),
    .bus_vld   (sel_vld),
    .tk_we     (tk_wr),
    .tk_addr   (tk_addr),
    .tk_wdata  (tk_wdata),
    .tk_byte   (tk_rdata),
    .stat_byte (stat_byte)
  );

  cmos_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rd_en     (bus_rd),
    .port_data (bus_a0),
    .state     (state_q),
    .idx       (idx_q),
    .sel_byte  (sel_byte),
    .sel_vld   (sel_vld),
    .tog_en    (tog_en),
    .rdata_q   (bus_rdata),
    .rerr_q    (bus_rerr)
  );

endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk
  import cmos_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              bus_a0,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rerr,
  input logic [ADDR_W-1:0] tk_addr,
  input logic              tk_wr,
  input logic [DATA_W-1:0] tk_wdata,
  input logic [DATA_W-1:0] tk_rdata,
  input logic [ADDR_W-1:0] idx_q,
  input idx_state_e        state_q,
  input logic [DATA_W-1:0] sel_byte,
  input logic              sel_vld,
  input logic [DATA_W-1:0] stat_byte
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_A_LOC);

  AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && !bus_a0) |=> (idx_q == $past(ADDR_W'(bus_wdata)))); // R1

  AST_IDX_READ: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && !bus_a0) |=> (bus_rdata == DATA_W'($past(idx_q)) && !bus_rerr)); // R1

  AST_READY_ERR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && bus_a0 && state_q == ST_READY) |=> (bus_rerr && bus_rdata == '0)); // R2

  AST_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_a0 && state_q == ST_POSTED) |=> (sel_vld && sel_byte == $past(bus_wdata))); // R3

  AST_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && bus_a0 && state_q == ST_POSTED && !sel_vld) |=> (bus_rerr && bus_rdata == '0)); // R4

  AST_UIP_FLIP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && bus_a0 && state_q == ST_POSTED && idx_q == STAT_ADDR)
      |=> (stat_byte == ($past(stat_byte) ^ 8'h80) && bus_rdata == $past(stat_byte))); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bus_rd |=> ($stable(bus_rdata) && $stable(bus_rerr))); // R7

  AST_SIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tk_wr && !(bus_wr && bus_a0 && state_q == ST_POSTED && idx_q == tk_addr)
       && !(bus_rd && bus_a0 && state_q == ST_POSTED && idx_q == STAT_ADDR && tk_addr == STAT_ADDR))
      |=> ((tk_addr != $past(tk_addr)) || tk_rdata == $past(tk_wdata))); // R8

  AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tk_wr && bus_wr && bus_a0 && state_q == ST_POSTED && idx_q == tk_addr)
      |=> (sel_byte == $past(bus_wdata))); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(bus_rd && bus_wr)); // input assumption

endmodule

bind cmos_regfile cmos_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .bus_a0    (bus_a0),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rerr  (bus_rerr),
  .tk_addr   (tk_addr),
  .tk_wr     (tk_wr),
  .tk_wdata  (tk_wdata),
  .tk_rdata  (tk_rdata),
  .idx_q     (idx_q),
  .state_q   (state_q),
  .sel_byte  (sel_byte),
  .sel_vld   (sel_vld),
  .stat_byte (stat_byte)
);

// File: tb/tb_cmos_regfile.sv
module tb_cmos_regfile;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_a0, bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_rerr;
  logic [7:0] tk_addr, tk_wdata, tk_rdata;
  logic       tk_wr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_mem [256];
  bit         m_vld [256];
  logic [7:0] m_idx;
  bit         m_posted;

  always #10 clk = ~clk;

  cmos_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
    .tk_addr(tk_addr), .tk_wr(tk_wr), .tk_wdata(tk_wdata), .tk_rdata(tk_rdata)
  );

  function automatic logic [7:0] reset_byte(input int loc);
    case (loc)
      6, 7, 8: return 8'h01;
      9:       return 8'h08;
      10:      return 8'h26;
      11:      return 8'h06;
      13:      return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_mem[i] = reset_byte(i);
      m_vld[i] = (i < 14);
    end
    m_idx = 8'h00;
    m_posted = 0;
  endtask

  task automatic bus_cycle(input bit a0, input bit rd, input bit wr, input logic [7:0] wd);
    @(negedge clk);
    bus_a0 = a0; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic idx_write(input logic [7:0] v);
    bus_cycle(0, 0, 1, v);
    m_idx = v; m_posted = 1;
  endtask

  task automatic data_write(input logic [7:0] v);
    bus_cycle(1, 0, 1, v);
    if (m_posted) begin
      m_mem[m_idx] = v; m_vld[m_idx] = 1;
    end
  endtask

  task automatic data_read(input string tag);
    logic [7:0] ed;
    bit ee;
    if (m_posted && m_vld[m_idx]) begin ed = m_mem[m_idx]; ee = 0; end
    else begin ed = 8'h00; ee = 1; end
    bus_cycle(1, 1, 0, 8'h00);
    chk(bus_rdata == ed && bus_rerr == ee, tag, {bus_rerr, bus_rdata}, {ee, ed});
    if (m_posted && m_vld[m_idx] && m_idx == 8'h0A) m_mem[10] = m_mem[10] ^ 8'h80;
  endtask

  task automatic idx_read(input string tag);
    bus_cycle(0, 1, 0, 8'h00);
    chk(bus_rdata == m_idx && !bus_rerr, tag, {bus_rerr, bus_rdata}, {1'b0, m_idx});
  endtask

  task automatic side_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    tk_addr = a; tk_wdata = v; tk_wr = 1;
    @(negedge clk);
    tk_wr = 0;
    m_mem[a] = v; m_vld[a] = 1;
  endtask

  task automatic side_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    tk_addr = a;
    #1;
    chk(tk_rdata == m_mem[a], tag, tk_rdata, m_mem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_d;
    bit hold_e;
    bus_a0 = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    tk_addr = 0; tk_wr = 0; tk_wdata = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Reset state of outputs and defaults (R6)
    chk(bus_rdata == 8'h00 && !bus_rerr, "R7 reset outputs", {bus_rerr, bus_rdata}, 0);
    for (int i = 0; i < 14; i++) side_read(8'(i), "R6 default byte");
    side_read(8'h0E, "R6 unwritten zero");

    // Ready state (R2), reset index (R1)
    idx_read("R1 reset index");
    data_read("R2 read before index");
    data_write(8'h55);
    side_read(8'h00, "R2 write ignored");

    // Index latch and unwritten location (R1, R4)
    idx_write(8'hC3);
    idx_read("R1 full index");
    side_read(8'hC3, "R1 storage untouched");
    data_read("R4 never written");
    idx_write(8'h0E);
    data_read("R4 first free location");
    data_write(8'h5A);
    data_read("R3 readback");

    // Status-A inversion (R5)
    idx_write(8'h0A);
    data_read("R5 first read");
    side_read(8'h0A, "R5 bit7 inverted");
    data_read("R5 second read");
    data_read("R5 third read");
    idx_write(8'h0B);
    data_read("R5 other location");
    side_read(8'h0B, "R5 no side effect");

    // Hold of read data (R7)
    idx_write(8'h09);
    data_read("R7 read");
    hold_d = bus_rdata; hold_e = bus_rerr;
    side_write(8'h09, 8'h77);
    idx_write(8'h20);
    repeat (3) @(negedge clk);
    chk(bus_rdata == hold_d && bus_rerr == hold_e, "R7 hold", bus_rdata, hold_d);

    // Side port (R8)
    side_write(8'h40, 8'h9C);
    side_read(8'h40, "R8 side write");
    idx_write(8'h40);
    data_read("R8 side write marks valid");

    // Collisions (R9)
    idx_write(8'h50);
    @(negedge clk);
    bus_a0 = 1; bus_wr = 1; bus_wdata = 8'hAA;
    tk_addr = 8'h50; tk_wdata = 8'hBB; tk_wr = 1;
    @(negedge clk);
    bus_wr = 0; tk_wr = 0;
    m_mem[8'h50] = 8'hAA; m_vld[8'h50] = 1;
    data_read("R9 same location bus wins");
    @(negedge clk);
    bus_a0 = 1; bus_wr = 1; bus_wdata = 8'h11;
    tk_addr = 8'h51; tk_wdata = 8'h22; tk_wr = 1;
    @(negedge clk);
    bus_wr = 0; tk_wr = 0;
    m_mem[8'h50] = 8'h11; m_mem[8'h51] = 8'h22; m_vld[8'h51] = 1;
    data_read("R9 bus side of split write");
    side_read(8'h51, "R9 side of split write");
    idx_write(8'h0A);
    @(negedge clk);
    bus_a0 = 1; bus_rd = 1;
    tk_addr = 8'h0A; tk_wdata = 8'h3C; tk_wr = 1;
    @(negedge clk);
    bus_rd = 0; tk_wr = 0;
    chk(bus_rdata == m_mem[10], "R9 toggle read value", bus_rdata, m_mem[10]);
    m_mem[10] = m_mem[10] ^ 8'h80;
    side_read(8'h0A, "R9 toggle beats side write");

    // Constrained random traffic
    void'($urandom(32'h00C0_FFEE));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, v;
      int op;
      op = int'($urandom_range(0, 5));
      a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
      v = 8'($urandom);
      case (op)
        0: idx_write(a);
        1: data_write(v);
        2: data_read("R3 random read");
        3: idx_read("R1 random index read");
        4: side_write(a, v);
        default: side_read(a, "R8 random side read");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule